// File: doc/BRIEF.md
# Multi-Domain Self-Clearing Software Reset

This block controls a software reset that spans several clock domains. Power-on, or a register write of 1 to the control bit, starts a reset sequence. The request is passed into every domain, and each domain holds its own reset output for a minimum number of its local clock cycles before it releases it. Each domain then sends an acknowledge back to the register clock domain. The readable status bit stays at 1 until every domain has confirmed its release, and then it clears itself. The slowest clock therefore sets the length of the whole sequence.

Software writes 1 to start a reset and polls the status bit. It must not reprogram anything until the bit reads 0. A write of 0 does nothing. A write of 1 while a sequence is already running is dropped, so one request always gives exactly one reset pulse in each domain. The handshake is four-phase: request up, all acknowledges up, request down, all acknowledges down. The status bit clears only when the last phase ends, so a new request can never overlap the tail of the previous one.

Top module: `soft_reset_ctrl`

## Requirements
- R1: While `reg_rst_n` is low, `rst_busy` reads 1 and every bit of `dom_rst` is 1 at once, with no clock edge needed.
- R2: After `reg_rst_n` is released, the power-on sequence finishes by itself. Every `dom_rst` bit returns to 0 and `rst_busy` then returns to 0.
- R3: A write (`wr_en` high with `wr_data` = 1) on a `reg_clk` edge while `rst_busy` is 0 makes `rst_busy` read 1 from that edge on.
- R4: Every assertion of `dom_rst[i]` lasts at least `HOLD_CYCLES` rising edges of `dom_clk[i]`. A software request asserts it, and it is released, on a rising edge of `dom_clk[i]`.
- R5: `rst_busy` is 1 whenever any `dom_rst` bit is 1. It falls to 0 only after every domain has released its reset and its acknowledge has returned to the register clock domain.
- R6: A write of 1 while `rst_busy` is 1 is ignored. Each domain sees exactly one reset pulse per accepted request.
- R7: A write with `wr_data` = 0 has no effect. `rst_busy` stays 0 and no `dom_rst` bit is asserted.
- R8: Once reset is released, `rst_busy` rises only on the edge that captures an accepted write of 1.
- R9: A write of 1 in the first cycle that `rst_busy` reads 0 is accepted and starts a full new sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reg_clk | input | 1 | Register interface clock |
| reg_rst_n | input | 1 | Active-low asynchronous power-on reset for all domains |
| wr_en | input | 1 | Write strobe for the control bit |
| wr_data | input | 1 | Written value of the control bit (1 requests a reset) |
| dom_clk | input | NUM_DOM | One clock per reset domain |
| dom_rst | output | NUM_DOM | Active-high reset per domain, released on its own clock |
| rst_busy | output | 1 | Readable control bit: 1 while a reset sequence is in progress |

## Verification
The assertions assume that every domain clock runs. Without it, a domain never acknowledges and the sequence never ends. They also assume that `reg_rst_n` is held long enough to be seen by all flops and is then released. The bench always drives free-running domain clocks with periods from well below to about four times the register period. It applies power-on reset only at the start and drives writes half a cycle away from the `reg_clk` edge. Extra writes during a sequence are placed only while the status bit still reads 1, so they test the drop path and not a new start.

// File: rtl/srst_pkg.sv
package srst_pkg;

    // Register-side handshake phase
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RAISE = 2'd1,
        PH_LOWER = 2'd2
    } hs_phase_e;

    // Per-domain reset state
    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_HOLD = 2'd1,
        DS_DONE = 2'd2
    } dom_state_e;

endpackage

// File: rtl/srst_sync.sv
module srst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q << 1;
        chain_d[0] = d;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/srst_domain.sv
module srst_domain
    import srst_pkg::*;
#(
    parameter int HOLD_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic dom_clk,
    input  logic por_n,
    input  logic req_async,
    output logic dom_rst,
    output logic ack
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        dom_state_e    st;
        logic [CW-1:0] cnt;
        logic          rst;
        logic          ack;
    } dom_regs_t;

    // Power-on: already holding, count starts at zero
    localparam dom_regs_t POR_VAL = '{st: DS_HOLD, cnt: '0, rst: 1'b1, ack: 1'b0};

    dom_regs_t s_d, s_q;
    logic      req_s;

    srst_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk    (dom_clk),
        .arst_n (por_n),
        .d      (req_async),
        .q      (req_s)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            DS_IDLE: begin
                if (req_s) begin
                    s_d.st  = DS_HOLD;
                    s_d.cnt = '0;
                    s_d.rst = 1'b1;
                end
            end
            DS_HOLD: begin
                if (s_q.cnt != CW'(HOLD_CYCLES - 1)) begin
                    s_d.cnt = CW'(s_q.cnt + 1'b1);
                end else if (req_s) begin
                    s_d.st  = DS_DONE;
                    s_d.rst = 1'b0;
                    s_d.ack = 1'b1;
                end
            end
            DS_DONE: begin
                if (!req_s) begin
                    s_d.st  = DS_IDLE;
                    s_d.ack = 1'b0;
                end
            end
            default: s_d = POR_VAL;
        endcase
    end

    always_ff @(posedge dom_clk or negedge por_n) begin
        if (!por_n) s_q <= POR_VAL;
        else        s_q <= s_d;
    end

    assign dom_rst = s_q.rst;
    assign ack     = s_q.ack;

endmodule

// File: rtl/srst_handshake.sv
module srst_handshake
    import srst_pkg::*;
#(
    parameter int NUM_DOM = 3
) (
    input  logic               reg_clk,
    input  logic               reg_rst_n,
    input  logic               wr_en,
    input  logic               wr_data,
    input  logic [NUM_DOM-1:0] ack_sync,
    output logic               req,
    output logic               busy
);

    typedef struct packed {
        hs_phase_e ph;
        logic      req;
    } hs_regs_t;

    localparam hs_regs_t POR_VAL = '{ph: PH_RAISE, req: 1'b1};

    hs_regs_t s_d, s_q;
    logic     all_up, all_down;

    assign all_up   = &ack_sync;
    assign all_down = ~|ack_sync;

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            PH_IDLE: begin
                if (wr_en && wr_data) begin
                    s_d.ph  = PH_RAISE;
                    s_d.req = 1'b1;
                end
            end
            PH_RAISE: begin
                if (all_up) begin
                    s_d.ph  = PH_LOWER;
                    s_d.req = 1'b0;
                end
            end
            PH_LOWER: begin
                if (all_down) s_d.ph = PH_IDLE;
            end
            default: s_d = POR_VAL;
        endcase
    end

    always_ff @(posedge reg_clk or negedge reg_rst_n) begin
        if (!reg_rst_n) s_q <= POR_VAL;
        else            s_q <= s_d;
    end

    assign req  = s_q.req;
    assign busy = (s_q.ph != PH_IDLE);

endmodule

// File: rtl/soft_reset_ctrl.sv
module soft_reset_ctrl #(
    parameter int NUM_DOM     = 3,
    parameter int HOLD_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               reg_clk,
    input  logic               reg_rst_n,
    input  logic               wr_en,
    input  logic               wr_data,
    input  logic [NUM_DOM-1:0] dom_clk,
    output logic [NUM_DOM-1:0] dom_rst,
    output logic               rst_busy
);

    logic               hs_req;
    logic [NUM_DOM-1:0] ack_raw;
    logic [NUM_DOM-1:0] ack_sync;

    srst_handshake #(.NUM_DOM(NUM_DOM)) u_hs (
        .reg_clk   (reg_clk),
        .reg_rst_n (reg_rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ack_sync  (ack_sync),
        .req       (hs_req),
        .busy      (rst_busy)
    );

    for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
        srst_domain #(
            .HOLD_CYCLES (HOLD_CYCLES),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_dom (
            .dom_clk   (dom_clk[i]),
            .por_n     (reg_rst_n),
            .req_async (hs_req),
            .dom_rst   (dom_rst[i]),
            .ack       (ack_raw[i])
        );

        srst_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
            .clk    (reg_clk),
            .arst_n (reg_rst_n),
            .d      (ack_raw[i]),
            .q      (ack_sync[i])
        );
    end

endmodule

// File: rtl/srst_checker.sv
module srst_checker #(
    parameter int NUM_DOM     = 3,
    parameter int HOLD_CYCLES = 4
) (
    input logic               reg_clk,
    input logic               reg_rst_n,
    input logic               wr_en,
    input logic               wr_data,
    input logic               rst_busy,
    input logic [NUM_DOM-1:0] dom_clk,
    input logic [NUM_DOM-1:0] dom_rst,
    input logic               hs_req,
    input logic [NUM_DOM-1:0] ack_sync
);

    // R3: accepted write raises the status bit on the next edge
    a_r3_write_starts: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        (wr_en && wr_data && !rst_busy) |=> rst_busy);

    // R8 / R6 / R7: status rises only from a captured write of 1
    a_r8_rise_from_write: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        $rose(rst_busy) |-> $past(wr_en && wr_data));

    // R5: status never low while a domain reset is active
    a_r5_busy_covers_rst: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        (|dom_rst) |-> rst_busy);

    // R5: status clears only with all domains released
    a_r5_clear_after_release: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        $fell(rst_busy) |-> (dom_rst == '0));

    // R5: request held until every domain has acknowledged
    a_r5_req_held: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        (hs_req && !(&ack_sync)) |=> hs_req);

    // R4: minimum hold per domain, measured with a local counter
    for (genvar g = 0; g < NUM_DOM; g++) begin : g_hold
        logic [15:0] hold_cnt;

        always_ff @(posedge dom_clk[g] or negedge reg_rst_n) begin
            if (!reg_rst_n)        hold_cnt <= '0;
            else if (!dom_rst[g])  hold_cnt <= '0;
            else if (hold_cnt != 16'hFFFF) hold_cnt <= hold_cnt + 16'd1;
        end

        a_r4_min_hold: assert property (@(posedge dom_clk[g]) disable iff (!reg_rst_n)
            $fell(dom_rst[g]) |-> (hold_cnt >= 16'(HOLD_CYCLES)));
    end

endmodule

bind soft_reset_ctrl srst_checker #(
    .NUM_DOM     (NUM_DOM),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_srst_checker (
    .reg_clk   (reg_clk),
    .reg_rst_n (reg_rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rst_busy  (rst_busy),
    .dom_clk   (dom_clk),
    .dom_rst   (dom_rst),
    .hs_req    (hs_req),
    .ack_sync  (ack_sync)
);

// File: tb/soft_reset_ctrl_bench.sv
module soft_reset_ctrl_bench;

    localparam int CLK_PERIOD  = 10;
    localparam int NUM_DOM     = 3;
    localparam int HOLD_CYCLES = 4;
    localparam int IDLE_LIMIT  = 5000;
    localparam int WDOG_LIMIT  = 150000;

    logic               reg_clk = 1'b0;
    logic               reg_rst_n = 1'b1;
    logic               wr_en = 1'b0;
    logic               wr_data = 1'b0;
    logic [NUM_DOM-1:0] dom_clk;
    logic [NUM_DOM-1:0] dom_rst;
    logic               rst_busy;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int pulses [NUM_DOM];
    int base   [NUM_DOM];
    int run_len[NUM_DOM];
    logic prev_busy = 1'b1;
    logic done = 1'b0;

    soft_reset_ctrl #(
        .NUM_DOM     (NUM_DOM),
        .HOLD_CYCLES (HOLD_CYCLES),
        .SYNC_STAGES (2)
    ) u_soft_reset_ctrl (
        .reg_clk   (reg_clk),
        .reg_rst_n (reg_rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .dom_clk   (dom_clk),
        .dom_rst   (dom_rst),
        .rst_busy  (rst_busy)
    );

    always #(CLK_PERIOD / 2) reg_clk = ~reg_clk;

    function automatic int half_of(int i);
        return 3 + 7 * i + i * i;
    endfunction

    function automatic logic exp_status(logic busy_before, logic d);
        return busy_before | d;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_clk
        localparam int HALF = half_of(g);
        logic c = 1'b0;
        initial forever #(HALF) c = ~c;
        assign dom_clk[g] = c;

        initial begin
            pulses[g]  = 0;
            run_len[g] = 0;
        end

        // R4: length of each local reset pulse in local cycles
        always @(negedge c) begin
            if (dom_rst[g] === 1'b1) begin
                run_len[g] = run_len[g] + 1;
            end else if (run_len[g] > 0) begin
                check(run_len[g] >= HOLD_CYCLES, "R4 hold length", run_len[g], HOLD_CYCLES);
                pulses[g]  = pulses[g] + 1;
                run_len[g] = 0;
            end
        end
    end

    // R5 / R6: status invariant and completion accounting
    always @(negedge reg_clk) begin
        if (reg_rst_n && !done) begin
            if (|dom_rst) check(rst_busy == 1'b1, "R5 busy while reset active", rst_busy, 1);
            if (prev_busy && !rst_busy) begin
                check(dom_rst == '0, "R5 all released at clear", int'(dom_rst), 0);
                for (int k = 0; k < NUM_DOM; k++) begin
                    check(pulses[k] - base[k] == 1, "R6 one pulse per request",
                          pulses[k] - base[k], 1);
                    base[k] = pulses[k];
                end
            end
            prev_busy = rst_busy;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge reg_clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_LIMIT);
            finish_run();
        end
    end

    // Caller stands at a negedge of reg_clk
    task automatic do_write(input logic d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge reg_clk);
        wr_en   = 1'b0;
        wr_data = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (rst_busy && n < IDLE_LIMIT) begin
            @(negedge reg_clk);
            n++;
        end
        check(!rst_busy, req, rst_busy, 0);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int k = 0; k < NUM_DOM; k++) base[k] = 0;

        // R1: asynchronous assertion at power-on
        #1 reg_rst_n = 1'b0;
        #1;
        check(rst_busy == 1'b1, "R1 status at power-on", rst_busy, 1);
        check(dom_rst == '1, "R1 domain resets at power-on", int'(dom_rst), (1 << NUM_DOM) - 1);
        repeat (3) @(negedge reg_clk);
        reg_rst_n = 1'b1;

        // R2: power-on sequence completes by itself
        wait_idle("R2 power-on completes");
        check(dom_rst == '0, "R2 all released", int'(dom_rst), 0);

        // R7: write of 0 while idle
        do_write(1'b0);
        check(rst_busy == exp_status(1'b0, 1'b0), "R7 write 0 status", rst_busy, 0);
        repeat (60) @(negedge reg_clk);
        check(!rst_busy, "R7 still idle", rst_busy, 0);
        for (int k = 0; k < NUM_DOM; k++)
            check(pulses[k] == base[k], "R7 no domain pulse", pulses[k] - base[k], 0);

        // R3 + R6: request then repeated writes while busy
        do_write(1'b1);
        check(rst_busy == 1'b1, "R3 status rises", rst_busy, 1);
        do_write(1'b1);
        @(negedge reg_clk);
        do_write(1'b1);
        wait_idle("R6 sequence ends");

        // R9: back-to-back request on the first idle cycle
        do_write(1'b1);
        check(rst_busy == 1'b1, "R9 back-to-back accepted", rst_busy, 1);
        wait_idle("R9 second sequence ends");

        // Random mix
        for (int it = 0; it < 40; it++) begin
            logic d;
            int gap;
            int extra;
            gap = $urandom_range(0, 5);
            repeat (gap) @(negedge reg_clk);
            d = 1'($urandom_range(0, 1));
            do_write(d);
            check(rst_busy == exp_status(1'b0, d), "R3 R7 random write", rst_busy, int'(d));
            if (d) begin
                extra = $urandom_range(0, 3);
                for (int e = 0; e < extra; e++) begin
                    repeat ($urandom_range(0, 3)) @(negedge reg_clk);
                    if (!rst_busy) break;
                    do_write(1'b1);   // R6: must be dropped
                end
                wait_idle("R5 random sequence ends");
            end else begin
                repeat (4) @(negedge reg_clk);
                check(!rst_busy, "R7 random write 0 idle", rst_busy, 0);
            end
        end

        repeat (5) @(negedge reg_clk);
        finish_run();
    end

endmodule